// File: doc/BRIEF.md
# Reset Cause Recorder

This block keeps a sticky record of every source that has reset the chip or woken it from system-off since the last power-on or brownout. Each source arrives as a single-cycle pulse. The pulse sets one flag in a 32-bit register, and software reads that register through a simple read/write port.

Flags build up over many resets. Software clears them one at a time by writing 1 to the bit it wants to clear. Only the power-on/brownout reset input clears the whole register. If software reads all zeros, the last reset came from the on-chip power-on or brownout generator.

Top module: `rst_cause_reg`

## Requirements
- R1: While `por_rst_n` is low, and right after it rises, `rdata` reads 32'h0000_0000.
- R2: A pulse on `ev_pin`, `ev_wdog`, `ev_soft` or `ev_lockup` sets bit 0, 1, 2 or 3 respectively. The bit reads 1 on the cycle after the pulse.
- R3: A pulse on `wk_gpio`, `wk_acmp`, `wk_dbg` or `wk_nfc` sets bit 16, 17, 18 or 19 respectively. The bit reads 1 on the cycle after the pulse.
- R4: Flags accumulate. A new cause, or several causes in the same cycle, sets its own bits and leaves every bit that is already set unchanged.
- R5: A write with `wr_en` high clears each flag whose `wdata` bit is 1. A 0 in `wdata` leaves the matching flag unchanged.
- R6: If a cause pulse and a write-1 clear hit the same bit in the same cycle, the bit is set after that cycle.
- R7: Bits other than 0–3 and 16–19 always read 0, even after a write of 1 to them.
- R8: A pulse on `por_rst_n` clears all flags. No cause pulse can clear a flag.
- R9: `wdata` has no effect when `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Power-on/brownout reset, asynchronous, active low |
| ev_pin | input | 1 | Pin reset pulse |
| ev_wdog | input | 1 | Watchdog reset pulse |
| ev_soft | input | 1 | Soft reset pulse |
| ev_lockup | input | 1 | CPU lockup reset pulse |
| wk_gpio | input | 1 | Wake from system-off by GPIO detect |
| wk_acmp | input | 1 | Wake from system-off by analog comparator detect |
| wk_dbg | input | 1 | Wake from system-off by debug interface entry |
| wk_nfc | input | 1 | Wake from system-off by NFC field detect |
| wr_en | input | 1 | Write strobe for the clear operation |
| wdata | input | 32 | Write-1-to-clear mask |
| rdata | output | 32 | Current flag register |

## Verification
All state sits in one register that drives `rdata` directly, so a wrong flag appears at the port on the cycle after the event that caused it. A lost set, a spurious clear, or a clear that wins over a set therefore shows within one cycle, and it stays visible until a later write or a reset. The sweep fires every combination of the eight sources together with rotating clear masks, and compares `rdata` against an arithmetic expectation every cycle. A wrongly routed bit or a stuck unused bit cannot stay hidden.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
    localparam int unsigned RCR_DATA_W    = 32;
    localparam int unsigned RCR_CORE_N    = 4;
    localparam int unsigned RCR_CORE_BASE = 0;
    localparam int unsigned RCR_WAKE_N    = 4;
    localparam int unsigned RCR_WAKE_BASE = 16;

    // Mask of implemented flag bits for a given layout
    function automatic logic [RCR_DATA_W-1:0] rcr_mask(
        input int unsigned core_n, input int unsigned core_base,
        input int unsigned wake_n, input int unsigned wake_base);
        logic [RCR_DATA_W-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < core_n; i++) m[core_base + i] = 1'b1;
        for (int unsigned i = 0; i < wake_n; i++) m[wake_base + i] = 1'b1;
        return m;
    endfunction

    typedef struct packed {
        logic [RCR_DATA_W-1:0] flags;
    } rcr_state_t;
endpackage

// File: rtl/rcr_event_map.sv
module rcr_event_map
    import rcr_pkg::*;
#(
    parameter int unsigned CORE_N    = RCR_CORE_N,
    parameter int unsigned CORE_BASE = RCR_CORE_BASE,
    parameter int unsigned WAKE_N    = RCR_WAKE_N,
    parameter int unsigned WAKE_BASE = RCR_WAKE_BASE
) (
    input  logic [CORE_N-1:0]     core_ev,
    input  logic [WAKE_N-1:0]     wake_ev,
    output logic [RCR_DATA_W-1:0] set_vec
);
    logic [RCR_DATA_W-1:0] core_part;
    logic [RCR_DATA_W-1:0] wake_part;

    // Each cause drives exactly one flag position
    for (genvar b = 0; b < RCR_DATA_W; b++) begin : g_pos
        if (b >= CORE_BASE && b < CORE_BASE + CORE_N) begin : g_core
            assign core_part[b] = core_ev[b - CORE_BASE];
        end else begin : g_core_none
            assign core_part[b] = 1'b0;
        end
        if (b >= WAKE_BASE && b < WAKE_BASE + WAKE_N) begin : g_wake
            assign wake_part[b] = wake_ev[b - WAKE_BASE];
        end else begin : g_wake_none
            assign wake_part[b] = 1'b0;
        end
    end

    assign set_vec = core_part | wake_part;
endmodule

// File: rtl/rcr_clear_decode.sv
module rcr_clear_decode
    import rcr_pkg::*;
#(
    parameter logic [RCR_DATA_W-1:0] IMPL_MASK = '1
) (
    input  logic                  wr_en,
    input  logic [RCR_DATA_W-1:0] wdata,
    output logic [RCR_DATA_W-1:0] clr_vec
);
    always_comb begin
        clr_vec = '0;
        if (wr_en) begin
            clr_vec = wdata & IMPL_MASK;
        end
    end
endmodule

// File: rtl/rcr_flag_store.sv
module rcr_flag_store
    import rcr_pkg::*;
#(
    parameter logic [RCR_DATA_W-1:0] IMPL_MASK = '1
) (
    input  logic                  clk,
    input  logic                  por_rst_n,
    input  logic [RCR_DATA_W-1:0] set_vec,
    input  logic [RCR_DATA_W-1:0] clr_vec,
    output logic [RCR_DATA_W-1:0] flags
);
    rcr_state_t state_d;
    rcr_state_t state_q;

    // Clear first, then set: a same-cycle set overrides the clear
    always_comb begin
        state_d       = state_q;
        state_d.flags = ((state_q.flags & ~clr_vec) | set_vec) & IMPL_MASK;
    end

    always_ff @(posedge clk or negedge por_rst_n) begin
        if (!por_rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flags = state_q.flags;
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
    import rcr_pkg::*;
(
    input  logic                  clk,
    input  logic                  por_rst_n,
    input  logic                  ev_pin,
    input  logic                  ev_wdog,
    input  logic                  ev_soft,
    input  logic                  ev_lockup,
    input  logic                  wk_gpio,
    input  logic                  wk_acmp,
    input  logic                  wk_dbg,
    input  logic                  wk_nfc,
    input  logic                  wr_en,
    input  logic [RCR_DATA_W-1:0] wdata,
    output logic [RCR_DATA_W-1:0] rdata
);
    localparam logic [RCR_DATA_W-1:0] IMPL_MASK =
        rcr_mask(RCR_CORE_N, RCR_CORE_BASE, RCR_WAKE_N, RCR_WAKE_BASE);

    logic [RCR_CORE_N-1:0] core_ev;
    logic [RCR_WAKE_N-1:0] wake_ev;
    logic [RCR_DATA_W-1:0] set_vec;
    logic [RCR_DATA_W-1:0] clr_vec;

    // Index order fixes the bit position of each cause
    assign core_ev = {ev_lockup, ev_soft, ev_wdog, ev_pin};
    assign wake_ev = {wk_nfc, wk_dbg, wk_acmp, wk_gpio};

    rcr_event_map #(
        .CORE_N    (RCR_CORE_N),
        .CORE_BASE (RCR_CORE_BASE),
        .WAKE_N    (RCR_WAKE_N),
        .WAKE_BASE (RCR_WAKE_BASE)
    ) u_map (
        .core_ev (core_ev),
        .wake_ev (wake_ev),
        .set_vec (set_vec)
    );

    rcr_clear_decode #(.IMPL_MASK(IMPL_MASK)) u_clr (
        .wr_en   (wr_en),
        .wdata   (wdata),
        .clr_vec (clr_vec)
    );

    rcr_flag_store #(.IMPL_MASK(IMPL_MASK)) u_store (
        .clk       (clk),
        .por_rst_n (por_rst_n),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .flags     (rdata)
    );
endmodule

// File: rtl/rst_cause_reg_chk.sv
module rst_cause_reg_chk (
    input logic        clk,
    input logic        por_rst_n,
    input logic        ev_pin,
    input logic        ev_wdog,
    input logic        ev_soft,
    input logic        ev_lockup,
    input logic        wk_gpio,
    input logic        wk_acmp,
    input logic        wk_dbg,
    input logic        wk_nfc,
    input logic        wr_en,
    input logic [31:0] wdata,
    input logic [31:0] rdata
);
    p_unused_zero_r7: assert property (@(posedge clk) disable iff (!por_rst_n)
        (rdata & 32'hFFF0_FFF0) == 32'h0);

    p_pin_sets_r2: assert property (@(posedge clk) disable iff (!por_rst_n)
        ev_pin |=> rdata[0]);

    p_lockup_sets_r2: assert property (@(posedge clk) disable iff (!por_rst_n)
        ev_lockup |=> rdata[3]);

    p_gpio_wake_sets_r3: assert property (@(posedge clk) disable iff (!por_rst_n)
        wk_gpio |=> rdata[16]);

    p_nfc_wake_sets_r3: assert property (@(posedge clk) disable iff (!por_rst_n)
        wk_nfc |=> rdata[19]);

    // R4/R9: a set flag only drops through an enabled write-1 clear
    p_sticky_r4: assert property (@(posedge clk) disable iff (!por_rst_n)
        (rdata[1] && !(wr_en && wdata[1])) |=> rdata[1]);

    p_clear_r5: assert property (@(posedge clk) disable iff (!por_rst_n)
        (wr_en && wdata[2] && !ev_soft) |=> !rdata[2]);

    p_set_wins_r6: assert property (@(posedge clk) disable iff (!por_rst_n)
        (wk_dbg && wr_en && wdata[18]) |=> rdata[18]);

    p_no_write_r9: assert property (@(posedge clk) disable iff (!por_rst_n)
        (!wr_en && !ev_wdog) |=> (rdata[1] == $past(rdata[1])));
endmodule

bind rst_cause_reg rst_cause_reg_chk u_chk (.*);

// File: tb/tb_rst_cause_reg.sv
`timescale 1ns/1ps
module tb_rst_cause_reg;
    logic        clk = 1'b0;
    logic        por_rst_n = 1'b0;
    logic [7:0]  src = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] exp_q = '0;
    int          n_chk = 0;
    int          n_err = 0;

    localparam logic [31:0] MASK = 32'h000F_000F;

    always #4 clk = ~clk;

    rst_cause_reg dut (
        .clk(clk), .por_rst_n(por_rst_n),
        .ev_pin(src[0]), .ev_wdog(src[1]), .ev_soft(src[2]), .ev_lockup(src[3]),
        .wk_gpio(src[4]), .wk_acmp(src[5]), .wk_dbg(src[6]), .wk_nfc(src[7]),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata)
    );

    // Source i maps to bit i (core) or 16+(i-4) (wake)
    function automatic logic [31:0] src_bits(input logic [7:0] s);
        return {12'h0, s[7:4], 12'h0, s[3:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: rdata=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Drive one cycle, update model, sample 1 ns after the capturing edge
    task automatic cycle(input string tag, input logic [7:0] s,
                         input logic w, input logic [31:0] d);
        @(negedge clk);
        src = s; wr_en = w; wdata = d;
        exp_q = ((exp_q & ~(w ? d : 32'h0)) | src_bits(s)) & MASK;
        @(posedge clk);
        #1;
        src = '0; wr_en = 1'b0; wdata = '0;
        check(tag, rdata, exp_q);
    endtask

    task automatic do_por();
        @(negedge clk);
        por_rst_n = 1'b0;
        exp_q = '0;
        #1;
        check("R8 cleared during power-on reset", rdata, 32'h0);
        @(negedge clk);
        @(negedge clk);
        por_rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 zero after power-on reset", rdata, 32'h0);
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog: rdata=%08h expected=finish", rdata);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #1;
        check("R1 value while reset held", rdata, 32'h0);
        do_por();

        // R2 / R3: each source alone from a clean register
        for (int i = 0; i < 8; i++) begin
            do_por();
            cycle(i < 4 ? "R2 core cause bit" : "R3 wake cause bit",
                  8'(1 << i), 1'b0, 32'h0);
        end

        // R4: accumulate one source at a time, nothing lost
        do_por();
        for (int i = 0; i < 8; i++) cycle("R4 accumulate", 8'(1 << i), 1'b0, 32'h0);
        check("R4 all flags set", rdata, 32'h000F_000F);

        // R9: write data without strobe
        cycle("R9 wdata without wr_en", 8'h00, 1'b0, 32'hFFFF_FFFF);
        @(negedge clk); wdata = 32'hFFFF_FFFF; @(posedge clk); #1; wdata = '0;
        check("R9 no strobe no clear", rdata, 32'h000F_000F);

        // R5: clear single bits, zeros keep
        cycle("R5 clear bit 1", 8'h00, 1'b1, 32'h0000_0002);
        check("R5 only bit 1 cleared", rdata, 32'h000F_000D);
        cycle("R5 clear bit 17", 8'h00, 1'b1, 32'h0002_0000);
        cycle("R5 write zero keeps", 8'h00, 1'b1, 32'h0000_0000);
        check("R5 zero write no effect", rdata, 32'h000D_000D);

        // R6: set and clear same bit, same cycle
        cycle("R6 set wins bit 1", 8'h02, 1'b1, 32'h0000_0002);
        check("R6 bit 1 set", rdata & 32'h2, 32'h2);
        cycle("R6 set wins bit 18", 8'h40, 1'b1, 32'h000F_000F);
        check("R6 only bit 18 left", rdata, 32'h0004_0000);

        // R7: unused bits cannot be set
        cycle("R7 write unused", 8'h00, 1'b1, 32'hFFF0_FFF0);
        check("R7 unused read zero", rdata & ~MASK, 32'h0);

        // R8: power-on clears everything accumulated
        cycle("R8 load flags", 8'hFF, 1'b0, 32'h0);
        do_por();

        // Sweep: every source combination with rotating clear masks (R4 R5 R6 R7)
        for (int m = 0; m < 256; m++) begin
            cycle("R4 sweep set", 8'(m), 1'b0, 32'h0);
            cycle("R5 sweep clear", 8'(m * 37), (m % 3) != 0,
                  32'(m * 32'h0001_3579) ^ {m[7:0], m[7:0], ~m[7:0], m[7:0]});
        end
        check("R7 sweep unused zero", rdata & ~MASK, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule